// File: doc/BRIEF.md
# Two-Way Write-Back Set-Associative Cache

This block sits between a 32-bit processor address bus and main memory and answers byte reads and byte writes from a small local store. The store is organised as sets of two lines each. Every line holds one data block, an address tag, a valid flag and a dirty flag. The processor raises a request and holds it until ready pulses for one cycle. On a hit, the answer comes back in the cycle after the request is accepted, and memory is not touched.

On a miss, the block picks a line in the addressed set. It fills an empty line if the set has one. Otherwise it takes the line that was not used most recently. If that line holds modified data, the block first writes the line back as one block-wide memory write. It then reads the whole missing block in one block-wide memory read, installs it, and serves the request from the new line. Writes update a single byte and mark the line as modified, so memory only sees modified data when a line is evicted.

The default build has 32-bit addresses, 8-byte blocks and 512 sets. This gives a 20-bit tag and 8 KB of data.

Top module: `twoway_wb_cache`

## Requirements
- R1: Reset clears every valid flag and dirty flag and every replacement bit. While reset is held and after it is released, `cpu_ready` and `mem_req` are low. The first access to any address after reset is a miss.
- R2: The address is split as follows: the low `OFF_W` bits select a byte within the block, the next `IDX_W` bits select the set, and the remaining high bits form the tag. Every memory transfer uses the address {tag, set, zeros}, where the tag is that of the line being moved.
- R3: When a request matches the tag of a valid line, `cpu_ready` is high for exactly one cycle, and that cycle is the one after the request is accepted. No memory transfer takes place. For a read, `cpu_rdata` holds the addressed byte in that cycle.
- R4: A read miss issues one block read (`mem_req`=1, `mem_we`=0). `cpu_ready` stays low until that read is acknowledged. The returned byte is the one at offset k of the block, where offset k occupies bits 8k+7:8k of the block bus.
- R5: A write hit changes only the addressed byte of the line. The other bytes of the line keep their values.
- R6: A write miss first allocates the block, reading it from memory. It then writes the byte into the line. The written value can be read back as a hit.
- R7: When the addressed set has an invalid line, a miss fills that line. The other valid line is left untouched and still hits afterwards.
- R8: Each set has one replacement bit. Every hit and every fill sets it to point at the other line. When both lines are valid, a miss replaces the line that was not used most recently.
- R9: A dirty victim is written to memory first (`mem_req`=1, `mem_we`=1, carrying the victim's address and the full contents of its line), and only then is the refill read issued. A clean victim causes no memory write.
- R10: `cpu_ready` is a single-cycle pulse. It is never high while a memory transfer is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | ADDR_W | Block-aligned memory address |
| mem_wdata | output | 8<<OFF_W | Block being written back |
| mem_ack | input | 1 | One-cycle completion of the memory transfer |
| mem_rdata | input | 8<<OFF_W | Block returned by a read, valid with `mem_ack` |

## Verification
The bench builds the block with `IDX_W`=2, so there are four sets. It keeps the default 8-byte block and a 27-bit tag. With so few sets, a handful of addresses that differ only in the tag land in one set. This quickly reaches the cases that a large set array makes rare: filling the second empty line, replacement chosen by recency, eviction of a clean line and write-back of a dirty one. Because the memory model answers with a fixed latency, miss and hit timing can be told apart by counting cycles at the ports.

// File: rtl/twc_pkg.sv
package twc_pkg;
  localparam int TWC_WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RESP,
    ST_WB,
    ST_FILL
  } twc_state_e;
endpackage

// File: rtl/twc_way_store.sv
module twc_way_store #(
  parameter int IDX_W = 9,
  parameter int TAG_W = 20,
  parameter int BLK_W = 64,
  localparam int SETS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [BLK_W-1:0] wr_data,
  input  logic             wr_dirty,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  output logic [BLK_W-1:0] rd_data
);
  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  dirty_q;
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [BLK_W-1:0] data_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[idx]  <= wr_tag;
      data_q[idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];
  assign rd_data  = data_q[idx];
endmodule

// File: rtl/twc_lru_table.sv
module twc_lru_table #(
  parameter int IDX_W = 9,
  localparam int SETS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             upd_en,
  input  logic             used_way,
  output logic             victim_way
);
  logic [SETS-1:0] older_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) older_q <= '0;
    else if (upd_en) older_q[idx] <= ~used_way;
  end

  assign victim_way = older_q[idx];
endmodule

// File: rtl/twoway_wb_cache.sv
module twoway_wb_cache
  import twc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 3,
  parameter int IDX_W  = 9,
  localparam int BLK_W = 8 << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BLK_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [BLK_W-1:0]  mem_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [OFF_W-1:0] f_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [7:0] f_pick(input logic [BLK_W-1:0] blk,
                                        input logic [OFF_W-1:0] off);
    return blk[{off, 3'b000} +: 8];
  endfunction

  function automatic logic [BLK_W-1:0] f_merge(input logic [BLK_W-1:0] blk,
                                               input logic [OFF_W-1:0] off,
                                               input logic [7:0] b);
    logic [BLK_W-1:0] r;
    r = blk;
    r[{off, 3'b000} +: 8] = b;
    return r;
  endfunction

  twc_state_e        st;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_way;
  logic [7:0]        rdata_q;

  logic [ADDR_W-1:0] cur_addr;
  logic [TAG_W-1:0]  cur_tag;
  logic [IDX_W-1:0]  cur_idx;
  logic [OFF_W-1:0]  cur_off;

  logic [TWC_WAYS-1:0] w_valid, w_dirty, w_hit, w_wr;
  logic [TAG_W-1:0]    w_tag  [TWC_WAYS];
  logic [BLK_W-1:0]    w_data [TWC_WAYS];

  logic             hit_any, hit_way, lru_victim, victim;
  logic             hit_ev, miss_ev, wb_ev, fill_ev;
  logic [BLK_W-1:0] hit_blk, wr_data;

  assign cur_addr = (st == ST_IDLE) ? cpu_addr : lat_addr;
  assign cur_tag  = f_tag(cur_addr);
  assign cur_idx  = f_idx(cur_addr);
  assign cur_off  = f_off(cur_addr);

  assign hit_any = |w_hit;
  assign hit_way = w_hit[1];
  assign hit_blk = w_data[hit_way];
  assign victim  = !w_valid[0] ? 1'b0 : (!w_valid[1] ? 1'b1 : lru_victim);

  assign hit_ev  = (st == ST_IDLE) && cpu_req && hit_any;
  assign miss_ev = (st == ST_IDLE) && cpu_req && !hit_any;
  assign wb_ev   = (st == ST_WB) && mem_ack;
  assign fill_ev = (st == ST_FILL) && mem_ack;

  assign wr_data = fill_ev ? mem_rdata : f_merge(hit_blk, cur_off, cpu_wdata);

  for (genvar w = 0; w < TWC_WAYS; w++) begin : g_way
    assign w_hit[w] = w_valid[w] && (w_tag[w] == cur_tag);
    assign w_wr[w]  = (hit_ev && cpu_we && (hit_way == 1'(w))) ||
                      (fill_ev && (lat_way == 1'(w)));

    twc_way_store #(
      .IDX_W(IDX_W),
      .TAG_W(TAG_W),
      .BLK_W(BLK_W)
    ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (cur_idx),
      .wr_en    (w_wr[w]),
      .wr_tag   (cur_tag),
      .wr_data  (wr_data),
      .wr_dirty (!fill_ev),
      .rd_valid (w_valid[w]),
      .rd_dirty (w_dirty[w]),
      .rd_tag   (w_tag[w]),
      .rd_data  (w_data[w])
    );
  end

  twc_lru_table #(.IDX_W(IDX_W)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (cur_idx),
    .upd_en     (hit_ev || fill_ev),
    .used_way   (fill_ev ? lat_way : hit_way),
    .victim_way (lru_victim)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      lat_addr <= '0;
      lat_way  <= 1'b0;
      rdata_q  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (hit_ev) begin
            rdata_q <= cpu_we ? cpu_wdata : f_pick(hit_blk, cur_off);
            st      <= ST_RESP;
          end else if (miss_ev) begin
            lat_addr <= cpu_addr;
            lat_way  <= victim;
            st       <= (w_valid[victim] && w_dirty[victim]) ? ST_WB : ST_FILL;
          end
        end
        ST_RESP: st <= ST_IDLE;
        ST_WB:   if (mem_ack) st <= ST_FILL;
        ST_FILL: if (mem_ack) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready = (st == ST_RESP);
  assign cpu_rdata = rdata_q;
  assign mem_req   = (st == ST_WB) || (st == ST_FILL);
  assign mem_we    = (st == ST_WB);
  assign mem_addr  = {((st == ST_WB) ? w_tag[lat_way] : cur_tag), cur_idx, {OFF_W{1'b0}}};
  assign mem_wdata = w_data[lat_way];
endmodule

// File: rtl/twoway_wb_cache_chk.sv
module twoway_wb_cache_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_ready,
  input logic mem_req,
  input logic mem_we,
  input logic hit_ev,
  input logic miss_ev,
  input logic wb_ev,
  input logic fill_ev
);
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  a_r10_no_ready_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  a_r3_hit_ready: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ev |=> cpu_ready);

  a_r4_miss_waits: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ev |=> (!cpu_ready && mem_req));

  a_r9_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ev |=> (mem_req && !mem_we));

  a_r4_fill_done: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ev |=> (!mem_req && !cpu_ready));
endmodule

bind twoway_wb_cache twoway_wb_cache_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_ready (cpu_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .hit_ev    (hit_ev),
  .miss_ev   (miss_ev),
  .wb_ev     (wb_ev),
  .fill_ev   (fill_ev)
);

// File: tb/twoway_wb_cache_tb.sv
module twoway_wb_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int OFF_W  = 3;
  localparam int IDX_W  = 2;
  localparam int BLK_W  = 8 << OFF_W;
  localparam int MEM_LAT = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [7:0]        cpu_wdata = '0;
  logic [7:0]        cpu_rdata;
  logic              cpu_ready, mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [BLK_W-1:0]  mem_wdata;
  logic              mem_ack = 1'b0;
  logic [BLK_W-1:0]  mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twoway_wb_cache #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  int total = 0, bad = 0;
  int fills = 0, wbs = 0;
  logic [ADDR_W-1:0] last_wb_addr = '0, last_fill_addr = '0;
  logic [BLK_W-1:0]  last_wb_data = '0;
  logic              rd_pending = 1'b0;
  bit                done = 1'b0;

  logic [BLK_W-1:0] mem_model [logic [ADDR_W-1:0]];
  logic [7:0]       ref_b     [logic [ADDR_W-1:0]];
  logic [7:0]       exp_q[$];

  function automatic logic [7:0] init_byte(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] ref_byte(input logic [ADDR_W-1:0] a);
    return ref_b.exists(a) ? ref_b[a] : init_byte(a);
  endfunction

  function automatic logic [BLK_W-1:0] ref_block(input logic [ADDR_W-1:0] base);
    logic [BLK_W-1:0] r;
    for (int k = 0; k < (1 << OFF_W); k++) r[k*8 +: 8] = ref_byte(base + ADDR_W'(k));
    return r;
  endfunction

  function automatic logic [BLK_W-1:0] init_block(input logic [ADDR_W-1:0] base);
    logic [BLK_W-1:0] r;
    for (int k = 0; k < (1 << OFF_W); k++) r[k*8 +: 8] = init_byte(base + ADDR_W'(k));
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: fixed-latency block responder, driven at the falling edge
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        cnt++;
        if (cnt == MEM_LAT) begin
          cnt = 0;
          mem_ack = 1'b1;
          if (mem_we) begin
            mem_model[mem_addr] = mem_wdata;
            wbs++;
            last_wb_addr = mem_addr;
            last_wb_data = mem_wdata;
          end else begin
            mem_rdata = mem_model.exists(mem_addr) ? mem_model[mem_addr]
                                                   : init_block(mem_addr);
            fills++;
            last_fill_addr = mem_addr;
          end
        end
      end else begin
        cnt = 0;
      end
    end
  end

  // monitor: pops expected read bytes as completions appear
  initial begin
    forever begin
      @(negedge clk);
      if (cpu_ready && mem_req) check(1'b0, "R10 ready during transfer", 1, 0);
      if (cpu_ready && rd_pending) begin
        if (exp_q.size() == 0) check(1'b0, "R3/R4 unexpected read", 0, 1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(cpu_rdata == e, "R3/R4/R5 read data", 64'(cpu_rdata), 64'(e));
        end
      end
    end
  end

  // driver: one request; exp_hit selects the latency check
  task automatic access(input logic [ADDR_W-1:0] a, input bit we, input logic [7:0] d,
                        input bit exp_hit, input int exp_fills, input int exp_wbs,
                        input string req);
    int cyc = 0;
    int f0 = fills;
    int w0 = wbs;
    @(negedge clk);
    if (!we) exp_q.push_back(ref_byte(a));
    rd_pending = !we;
    cpu_addr = a; cpu_we = we; cpu_wdata = d; cpu_req = 1'b1;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 200);
    cpu_req = 1'b0;
    if (we) ref_b[a] = d;
    if (exp_hit) check(cyc == 1, {req, " hit latency"}, 64'(cyc), 1);
    else         check(cyc > 1 && cyc < 200, {req, " miss latency"}, 64'(cyc), 2);
    check(fills - f0 == exp_fills, {req, " block reads"}, 64'(fills - f0), 64'(exp_fills));
    check(wbs - w0 == exp_wbs, {req, " block writes"}, 64'(wbs - w0), 64'(exp_wbs));
    @(negedge clk);
    check(!cpu_ready, "R10 ready pulse width", 64'(cpu_ready), 0);
    rd_pending = 1'b0;
  endtask

  localparam logic [ADDR_W-1:0] A = 32'h0000_1008; // set 1
  localparam logic [ADDR_W-1:0] B = 32'h0000_2008; // set 1
  localparam logic [ADDR_W-1:0] C = 32'h0000_3008; // set 1
  localparam logic [ADDR_W-1:0] D = 32'h0000_4008; // set 1
  localparam logic [ADDR_W-1:0] E = 32'h0000_5010; // set 2

  initial begin
    repeat (3) @(negedge clk);
    check(!cpu_ready && !mem_req, "R1 quiet in reset", 64'({cpu_ready, mem_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cpu_ready && !mem_req, "R1 quiet after reset", 64'({cpu_ready, mem_req}), 0);

    access(A + 3, 1'b0, 8'h00, 1'b0, 1, 0, "R1 R4 first read miss");
    check(last_fill_addr == A, "R2 R4 fill address aligned", 64'(last_fill_addr), 64'(A));
    access(A + 5, 1'b0, 8'h00, 1'b1, 0, 0, "R3 read hit");
    access(A + 5, 1'b1, 8'hC3, 1'b1, 0, 0, "R5 write hit");
    access(A + 5, 1'b0, 8'h00, 1'b1, 0, 0, "R5 read written byte");
    access(A + 4, 1'b0, 8'h00, 1'b1, 0, 0, "R5 neighbour byte kept");
    access(A + 6, 1'b0, 8'h00, 1'b1, 0, 0, "R5 upper neighbour kept");

    access(B, 1'b0, 8'h00, 1'b0, 1, 0, "R7 fill empty line");
    access(A + 5, 1'b0, 8'h00, 1'b1, 0, 0, "R7 other line kept");
    access(C + 1, 1'b0, 8'h00, 1'b0, 1, 0, "R8 R9 clean victim B");
    access(A + 2, 1'b0, 8'h00, 1'b1, 0, 0, "R8 recent line kept");
    access(B + 7, 1'b0, 8'h00, 1'b0, 1, 0, "R8 B evicted");
    access(D, 1'b0, 8'h00, 1'b0, 1, 1, "R9 dirty victim A");
    check(last_wb_addr == A, "R9 write-back address", 64'(last_wb_addr), 64'(A));
    check(last_wb_data == ref_block(A), "R9 write-back data",
          last_wb_data, ref_block(A));
    access(A + 5, 1'b0, 8'h00, 1'b0, 1, 0, "R9 refetch written data");

    access(E + 2, 1'b1, 8'h3C, 1'b0, 1, 0, "R6 write miss allocate");
    access(E + 2, 1'b0, 8'h00, 1'b1, 0, 0, "R6 read allocated byte");
    access(E + 3, 1'b0, 8'h00, 1'b1, 0, 0, "R6 rest of block filled");

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    access(D + 4, 1'b0, 8'h00, 1'b0, 1, 0, "R1 miss after reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule